// File: doc/BRIEF.md
# Lookup-Table Logic Element with Maskable Reset

This block is one cell of a fine-grained programmable fabric. A 4-input lookup table picks one of 16 stored truth-table bits, using the four data inputs as an index. A flip-flop behind the table can either be bypassed, so the cell acts as plain combinational logic, or placed in the path, so the cell presents a registered result. All programming values (truth table, path select, reset polarity select, reset block) are static inputs. In the fabric they would come from configuration storage, which is outside this block.

The fabric-wide reset is active-low and acts on the clock edge. It reaches this cell's flip-flop only when the cell's reset-block bit is clear. When it does act, it forces the flip-flop to the programmed level, 0 or 1. This lets a freshly loaded region be initialised while the cells of a running region keep working through the same global reset pulse. Those running cells have the reset-block bit set.

Top module: `lut_le`

## Requirements
- R1: With `reg_mode` = 0, `le_out` equals bit `sel_in` of `lut_mask` (bit k is chosen when the unsigned value of `sel_in` is k), with no clock edge involved.
- R2: With `rst_n` = 1, each rising `clk` edge loads the flip-flop with bit `sel_in` of `lut_mask` as sampled at that edge. With `reg_mode` = 1, `le_out` shows that value until the next edge.
- R3: On a rising edge where `rst_n` = 0, `rst_block` = 0 and `rst_to_one` = 1, the flip-flop loads 1 whatever the table selects.
- R4: On a rising edge where `rst_n` = 0, `rst_block` = 0 and `rst_to_one` = 0, the flip-flop loads 0 whatever the table selects.
- R5: On a rising edge where `rst_block` = 1, `rst_n` has no effect. The flip-flop loads the table bit exactly as in R2, for either value of `rst_to_one`.
- R6: With every programming input and data input at 0, `le_out` is 0 in combinational mode.
- R7: The flip-flop keeps clocking while `reg_mode` = 0. Setting `reg_mode` to 1 between edges makes `le_out` show the value captured at the most recent edge at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric-wide clock |
| rst_n | input | 1 | Fabric-wide reset, active low, sampled on the clock edge |
| sel_in | input | 4 | Data inputs, used as the lookup index |
| lut_mask | input | 16 | Truth table; bit k is the result for index k |
| reg_mode | input | 1 | 1 = registered output, 0 = direct table output |
| rst_to_one | input | 1 | Level loaded by reset: 1 forces high, 0 forces low |
| rst_block | input | 1 | 1 = this cell ignores the global reset |
| le_out | output | 1 | Cell output |

## Verification
The assertions assume that the programming inputs and data inputs change only between clock edges and never at a rising edge. Under that assumption, the values sampled at an edge are the values the flip-flop captured. They also assume that a flip-flop property is judged only from the second edge onward, when the previous edge has given the register a defined value. The bench changes every input on the falling edge and keeps the random sequence running from the start of the run. It first applies a reset-low cycle so the flip-flop holds a known level before any registered output is compared.

// File: rtl/lut_le_pkg.sv
package lut_le_pkg;
  localparam int unsigned LE_SEL_W = 4;

  typedef enum logic {
    RV_CLEAR = 1'b0,
    RV_SET   = 1'b1
  } rst_val_e;

  function automatic logic rst_level(input rst_val_e v);
    return (v == RV_SET) ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/lut_le_table.sv
module lut_le_table #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned TBL_N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [TBL_N-1:0] table_bits,
  output logic             bit_out
);
  genvar l, n;
  generate
    for (l = 0; l < SEL_W; l++) begin : g_lvl
      localparam int unsigned W = TBL_N >> (l + 1);
      logic [W-1:0] node;
      for (n = 0; n < W; n++) begin : g_node
        if (l == 0) begin : g_leaf
          assign node[n] = sel[0] ? table_bits[2*n+1] : table_bits[2*n];
        end else begin : g_inner
          assign node[n] = sel[l] ? g_lvl[l-1].node[2*n+1] : g_lvl[l-1].node[2*n];
        end
      end
    end
  endgenerate

  assign bit_out = g_lvl[SEL_W-1].node[0];
endmodule

// File: rtl/lut_le_reg.sv
module lut_le_reg
  import lut_le_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rst_block,
  input  rst_val_e rst_val,
  input  logic     d_in,
  output logic     q
);
  logic rst_hit;
  logic q_next;

  always_comb begin
    rst_hit = ~rst_n & ~rst_block;
    q_next  = rst_hit ? rst_level(rst_val) : d_in;
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end
endmodule

// File: rtl/lut_le_outsel.sv
module lut_le_outsel (
  input  logic use_reg,
  input  logic comb_val,
  input  logic reg_val,
  output logic y
);
  always_comb begin
    y = use_reg ? reg_val : comb_val;
  end
endmodule

// File: rtl/lut_le.sv
module lut_le
  import lut_le_pkg::*;
#(
  parameter int unsigned SEL_W = LE_SEL_W,
  localparam int unsigned TBL_N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [TBL_N-1:0] lut_mask,
  input  logic             reg_mode,
  input  logic             rst_to_one,
  input  logic             rst_block,
  output logic             le_out
);
  logic     lut_bit;
  logic     ff_q;
  rst_val_e rv;

  assign rv = rst_to_one ? RV_SET : RV_CLEAR;

  lut_le_table #(.SEL_W(SEL_W)) u_table (
    .sel        (sel_in),
    .table_bits (lut_mask),
    .bit_out    (lut_bit)
  );

  lut_le_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_block (rst_block),
    .rst_val   (rv),
    .d_in      (lut_bit),
    .q         (ff_q)
  );

  lut_le_outsel u_out (
    .use_reg  (reg_mode),
    .comb_val (lut_bit),
    .reg_val  (ff_q),
    .y        (le_out)
  );
endmodule

// File: rtl/lut_le_checker.sv
module lut_le_checker #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned TBL_N = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel_in,
  input logic [TBL_N-1:0] lut_mask,
  input logic             reg_mode,
  input logic             rst_to_one,
  input logic             rst_block,
  input logic             le_out
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  a_r1_comb_path: assert property (@(posedge clk) disable iff (!primed)
    !reg_mode |-> (le_out == lut_mask[sel_in]));

  a_r2_reg_path: assert property (@(posedge clk) disable iff (!primed)
    rst_n |=> (!reg_mode || le_out == $past(lut_mask[sel_in])));

  a_r3_reset_high: assert property (@(posedge clk) disable iff (!primed)
    (!rst_n && !rst_block && rst_to_one) |=> (!reg_mode || le_out));

  a_r4_reset_low: assert property (@(posedge clk) disable iff (!primed)
    (!rst_n && !rst_block && !rst_to_one) |=> (!reg_mode || !le_out));

  a_r5_reset_blocked: assert property (@(posedge clk) disable iff (!primed)
    rst_block |=> (!reg_mode || le_out == $past(lut_mask[sel_in])));
endmodule

bind lut_le lut_le_checker #(.SEL_W(SEL_W)) u_lut_le_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_in     (sel_in),
  .lut_mask   (lut_mask),
  .reg_mode   (reg_mode),
  .rst_to_one (rst_to_one),
  .rst_block  (rst_block),
  .le_out     (le_out)
);

// File: tb/lut_le_test.sv
module lut_le_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  sel_in;
  logic [15:0] lut_mask;
  logic        reg_mode;
  logic        rst_to_one;
  logic        rst_block;
  logic        le_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  logic exp_q;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  lut_le uut (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .lut_mask(lut_mask),
    .reg_mode(reg_mode), .rst_to_one(rst_to_one), .rst_block(rst_block),
    .le_out(le_out)
  );

  function automatic logic pick(input logic [15:0] m, input logic [3:0] s);
    return (m >> s) & 16'd1;
  endfunction

  function automatic logic ff_model(input logic rn, input logic blk,
                                    input logic one, input logic lut);
    if (!rn && !blk) return one;
    return lut;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: le_out=%0b expected %0b", req, act, exp);
    end
  endtask

  // Drive inputs on the falling edge, take one rising edge, check at the next falling edge.
  task automatic step(input logic rn, input logic blk, input logic one,
                      input logic rm, input logic [15:0] m, input logic [3:0] s);
    string req;
    rst_n = rn; rst_block = blk; rst_to_one = one;
    reg_mode = rm; lut_mask = m; sel_in = s;
    @(posedge clk);
    exp_q = ff_model(rn, blk, one, pick(m, s));
    @(negedge clk);
    if (!rm) req = "R1";
    else if (!rn && !blk) req = one ? "R3" : "R4";
    else if (!rn) req = "R5";
    else req = "R2";
    check(req, le_out, rm ? exp_q : pick(m, s));
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b1; rst_block = 1'b0; rst_to_one = 1'b0;
    reg_mode = 1'b0; lut_mask = 16'h0000; sel_in = 4'h0;
    #1;
    check("R6", le_out, 1'b0);  // R6: all-zero configuration
    @(negedge clk);
    check("R6", le_out, 1'b0);

    // R4: reset forces low although table selects 1
    step(1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 4'h5);
    // R3: reset forces high although table selects 0
    step(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 4'hA);
    // R5: blocked reset, table gives 0 while reset would set 1
    step(1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 4'h3);
    // R5: blocked reset, table gives 1 while reset would clear
    step(1'b0, 1'b1, 1'b0, 1'b1, 16'h8000, 4'hF);
    // R2: boundary indices
    step(1'b1, 1'b0, 1'b0, 1'b1, 16'h0001, 4'h0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 16'h7FFF, 4'hF);
    // R1: each index of a walking-one table
    for (int k = 0; k < 16; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1 << k, 4'(k));

    // R7: capture in combinational mode, then switch to registered between edges
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0010, 4'h4);
    lut_mask = 16'h0000;
    reg_mode = 1'b1;
    #1;
    check("R7", le_out, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 4'h0);
    reg_mode = 1'b1;
    #1;
    check("R7", le_out, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[2:0] != 3'd0), r[3], r[4], r[5], 16'($urandom), r[9:6]);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule